// File: doc/BRIEF.md
# Read-Triggered Down-Counting Interval Timer

This block is the interval timer of a dual-channel serial controller. Software sets a 16-bit preset by writing its upper and lower bytes at two separate addresses, and can read either byte back at the same addresses. A count is started by a bus read of one dedicated address and cancelled by a bus read of another, not by writes. Both of these reads return zero and clear any pending timer-expired status.

While a count runs, the counter moves down one step on each single-cycle pulse of the `tick` input. The step pulse is meant to arrive about every 4.34 microseconds, so the total delay is the preset value multiplied by the step time. When the count ends, the block sets its timer-expired bit. That bit feeds the controller's shared interrupt status, and the block raises its interrupt request when the matching mask bit is also set.

Top module: `rdtrig_timer`

## Requirements
- R1: After reset the preset is zero, the counter is idle, `tmr_ready`, `irq` and `rd_data` are 0, and preset readback gives 0.
- R2: A write to address 0 replaces preset bits 15:8 and leaves bits 7:0 unchanged.
- R3: A write to address 1 replaces preset bits 7:0 and leaves bits 15:8 unchanged.
- R4: A read of address 0 returns preset bits 15:8, and a read of address 1 returns bits 7:0. The value appears on `rd_data` in the cycle after the read strobe.
- R5: A read of address 2 returns 0, clears `tmr_ready`, loads the counter from the preset and starts it.
- R6: A read of address 3 returns 0, clears `tmr_ready` (and so drops `irq`), and cancels any running count so that later ticks never set `tmr_ready`.
- R7: With a preset N of at least 1, `tmr_ready` rises on the Nth `tick` after the start read and not before. Ticks while the counter is idle have no effect.
- R8: With a preset of 0, `tmr_ready` rises on the first `tick` after the start read.
- R9: A start read while a count is running reloads the counter from the preset and restarts the full count.
- R10: `irq` is high exactly when `tmr_ready` is set and `irq_mask` is high.
- R11: Once set, `tmr_ready` stays set through further ticks until a start or stop read.
- R12: Writing the preset while a count runs does not change the count in progress. The new value takes effect at the next start read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| tick | input | 1 | Single-cycle count-step pulse |
| irq_mask | input | 1 | Timer bit of the interrupt mask |
| tmr_ready | output | 1 | Timer-expired bit for the shared interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks that expiry lands on exactly the Nth tick, one tick early and on time. It does this for small presets and for a preset that needs a borrow across the byte boundary. An off-by-one terminal test would make the early check fail. A preset of 0 must expire on the first tick; a design that decrements first would wrap and wait 65536 steps instead. The bench also covers a restart while running, a preset write during a count and ticks after a stop. A design that ignored the reload, tracked the live preset or kept counting after cancel would set `tmr_ready` at the wrong time. Byte-write isolation is checked by reading back the byte that was not written.

// File: rtl/rdtrig_pkg.sv
package rdtrig_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_CANCEL = 2'd2,
    CNT_STEP   = 2'd3
  } cnt_action_e;

  // True when the current value is the final step of a count.
  function automatic logic is_last_step(input logic [31:0] value);
    return value <= 32'd1;
  endfunction

  function automatic logic [31:0] step_down(input logic [31:0] value);
    return value - 32'd1;
  endfunction

  function automatic cnt_action_e pick_action(input logic load, input logic cancel,
                                              input logic running, input logic tick);
    if (load)                return CNT_LOAD;
    else if (cancel)         return CNT_CANCEL;
    else if (running && tick) return CNT_STEP;
    else                     return CNT_HOLD;
  endfunction

endpackage

// File: rtl/rdtrig_preset.sv
module rdtrig_preset #(
  parameter int CNT_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int BASE_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [CNT_W-1:0]    preset,
  output logic [CNT_W/BYTE_W-1:0] wr_lane,
  output logic [BYTE_W-1:0]   rd_byte
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] lane_q [NBYTES];
  logic [NBYTES-1:0] lane_sel;

  // Lane NBYTES-1 (most significant) sits at BASE_ADDR.
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + NBYTES - 1 - i);

    assign lane_sel[i] = (addr == LANE_ADDR);
    assign wr_lane[i]  = wr_en && lane_sel[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q[i] <= '0;
      end else if (wr_lane[i]) begin
        lane_q[i] <= wr_data;
      end
    end

    assign preset[i*BYTE_W +: BYTE_W] = lane_q[i];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (lane_sel[i]) rd_byte = lane_q[i];
    end
  end

endmodule

// File: rtl/rdtrig_down.sv
module rdtrig_down #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cancel,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic             running,
  output logic             expire_ev,
  output logic             ready
);
  import rdtrig_pkg::*;

  logic [CNT_W-1:0] count_q;
  cnt_action_e      action;
  logic             last_step;

  assign action    = pick_action(load, cancel, running, tick);
  assign last_step = is_last_step(32'(count_q));
  assign expire_ev = (action == CNT_STEP) && last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      running <= 1'b0;
      ready   <= 1'b0;
    end else begin
      case (action)
        CNT_LOAD: begin
          count_q <= preset;
          running <= 1'b1;
          ready   <= 1'b0;
        end
        CNT_CANCEL: begin
          running <= 1'b0;
          ready   <= 1'b0;
        end
        CNT_STEP: begin
          if (last_step) begin
            running <= 1'b0;
            ready   <= 1'b1;
          end else begin
            count_q <= CNT_W'(step_down(32'(count_q)));
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rdtrig_timer.sv
module rdtrig_timer #(
  parameter int CNT_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int BASE_ADDR  = 0,
  parameter int START_ADDR = 2,
  parameter int STOP_ADDR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tick,
  input  logic              irq_mask,
  output logic              tmr_ready,
  output logic              irq
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);
  localparam logic [ADDR_W-1:0] STOP_A  = ADDR_W'(STOP_ADDR);

  logic [CNT_W-1:0]  preset;
  logic [NBYTES-1:0] wr_lane;
  logic [BYTE_W-1:0] rd_byte;
  logic              start_ev;
  logic              stop_ev;
  logic              running;
  logic              expire_ev;

  assign start_ev = rd_en && (addr == START_A);
  assign stop_ev  = rd_en && (addr == STOP_A);

  rdtrig_preset #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_preset (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .preset(preset), .wr_lane(wr_lane), .rd_byte(rd_byte)
  );

  rdtrig_down #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst_n(rst_n), .load(start_ev), .cancel(stop_ev), .tick(tick),
    .preset(preset), .running(running), .expire_ev(expire_ev), .ready(tmr_ready)
  );

  // Start/stop addresses read as zero; preset lanes read back their byte.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= (start_ev || stop_ev) ? '0 : rd_byte;
    end
  end

  assign irq = tmr_ready && irq_mask;

endmodule

// File: rtl/rdtrig_timer_chk.sv
module rdtrig_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CNT_W-1:0]         preset,
  input logic [CNT_W/BYTE_W-1:0]  wr_lane,
  input logic                     start_ev,
  input logic                     stop_ev,
  input logic                     expire_ev,
  input logic                     running,
  input logic                     tmr_ready,
  input logic                     irq,
  input logic                     irq_mask,
  input logic [BYTE_W-1:0]        rd_data
);
  localparam int NB = CNT_W / BYTE_W;

  // R2
  upper_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane[NB-1] |=> preset[BYTE_W-1:0] == $past(preset[BYTE_W-1:0]));

  // R3
  lower_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane[0] |=> preset[CNT_W-1:CNT_W-BYTE_W] == $past(preset[CNT_W-1:CNT_W-BYTE_W]));

  // R5
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> running && !tmr_ready && rd_data == '0);

  // R6
  stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !running && !tmr_ready && !irq && rd_data == '0);

  // R7
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_ready) |-> $past(expire_ev));

  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ready && !start_ev && !stop_ev |=> tmr_ready);

  // R10
  irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tmr_ready && irq_mask);

endmodule

bind rdtrig_timer rdtrig_timer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .preset(preset), .wr_lane(wr_lane),
  .start_ev(start_ev), .stop_ev(stop_ev), .expire_ev(expire_ev),
  .running(running), .tmr_ready(tmr_ready), .irq(irq), .irq_mask(irq_mask),
  .rd_data(rd_data)
);

// File: tb/rdtrig_timer_bench.sv
module rdtrig_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       irq_mask = 1'b0;
  logic       tmr_ready;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rdtrig_timer u_rdtrig_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .irq_mask(irq_mask),
    .tmr_ready(tmr_ready), .irq(irq)
  );

  // {is_write, addr[1:0], data[7:0], expected_read[7:0]}
  localparam logic [18:0] VEC [12] = '{
    {1'b1, 2'd0, 8'hA5, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'hA5},
    {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'h3C, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'hA5},
    {1'b0, 2'd1, 8'h00, 8'h3C},
    {1'b1, 2'd0, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h3C},
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'hFF, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_preset(input logic [15:0] v);
    bus_wr(2'd0, v[15:8]);
    bus_wr(2'd1, v[7:0]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    irq_mask = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 ready", tmr_ready, 0);
    check("R1 irq", irq, 0);
    check("R1 rd_data", rd_data, 0);
    bus_rd(2'd0); check("R1 upper preset", rd_data, 0);
    bus_rd(2'd1); check("R1 lower preset", rd_data, 0);
    ticks(3);    check("R1 idle ticks", tmr_ready, 0);

    // R2 R3 R4 byte writes and readback
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][18]) bus_wr(VEC[v][17:16], VEC[v][15:8]);
      else begin
        bus_rd(VEC[v][17:16]);
        check("R2 R3 R4 byte readback", rd_data, VEC[v][7:0]);
      end
    end

    // R5 R7 R10 R11: preset 5
    set_preset(16'd5);
    irq_mask = 1'b0;
    bus_rd(2'd2);
    check("R5 start reads zero", rd_data, 0);
    check("R5 ready clear", tmr_ready, 0);
    ticks(4); check("R7 not before Nth tick", tmr_ready, 0);
    ticks(1); check("R7 on Nth tick", tmr_ready, 1);
    check("R10 masked irq", irq, 0);
    irq_mask = 1'b1; #1;
    check("R10 unmasked irq", irq, 1);
    ticks(3); check("R11 ready sticky", tmr_ready, 1);
    bus_rd(2'd2);
    check("R5 start clears ready", tmr_ready, 0);
    check("R10 irq drops", irq, 0);
    bus_rd(2'd3);

    // R6 stop cancels and clears
    set_preset(16'd3);
    bus_rd(2'd2); ticks(1);
    bus_rd(2'd3);
    check("R6 stop reads zero", rd_data, 0);
    ticks(5); check("R6 cancelled count", tmr_ready, 0);
    bus_rd(2'd2); ticks(3);
    check("R6 setup ready", tmr_ready, 1);
    bus_rd(2'd3);
    check("R6 stop clears ready", tmr_ready, 0);
    check("R6 stop drops irq", irq, 0);
    ticks(2); check("R7 idle ticks ignored", tmr_ready, 0);

    // R8 preset zero
    set_preset(16'd0);
    bus_rd(2'd2); check("R8 not before tick", tmr_ready, 0);
    ticks(1); check("R8 first tick", tmr_ready, 1);

    // R9 restart
    set_preset(16'd4);
    bus_rd(2'd2); ticks(3);
    check("R9 before restart", tmr_ready, 0);
    bus_rd(2'd2); ticks(3);
    check("R9 restarted full count", tmr_ready, 0);
    ticks(1); check("R9 expiry after reload", tmr_ready, 1);

    // R12 write during count
    set_preset(16'd4);
    bus_rd(2'd2);
    bus_wr(2'd1, 8'd1);
    ticks(3); check("R12 write ignored by live count", tmr_ready, 0);
    ticks(1); check("R12 original count expires", tmr_ready, 1);
    bus_rd(2'd2); ticks(1);
    check("R12 new preset on next start", tmr_ready, 1);

    // R7 borrow across byte boundary
    set_preset(16'h0102);
    bus_rd(2'd2); ticks(257);
    check("R7 large preset early", tmr_ready, 0);
    ticks(1); check("R7 large preset on time", tmr_ready, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule